// File: doc/BRIEF.md
# Doorbell and Queue Interrupt Status Word

This block forms the 32-bit interrupt status word of an inter-processor messaging unit. It holds fifteen doorbell event bits. Each bit is set by a one-cycle pulse from the doorbell source and stays set until software reads the word. It also derives eight queue attention flags from the pointers of four send queues and four receive queues.

A receive queue raises its flag when it holds data. A send queue raises its flag when it has room and its enable bit is on. Two 4-bit fields in the word name the most urgent pending doorbell and the most urgent pending queue flag. The lowest index wins, and the value 15 means nothing is pending. A single interrupt line is high while any doorbell or queue flag is set.

Software reads the word through a simple read port. The read data is always the live word. Asserting the read strobe for a cycle clears every doorbell bit at the following clock edge. The queue flags are not cleared by the read, because they follow the pointers. The queue storage, the interrupt controller and the bus are outside this block.

Top module: `msg_irq_status`

## Requirements
- R1: After reset, with all pointers equal, every send enable low and no doorbell pulse, the read word is 0xFF000000.
- R2: A high bit i (0 to 14) on bellSet sets word bit i at the next clock edge. The bit then stays set until a clearing read. Word bit 15 always reads 0.
- R3: When rdEn is high in a cycle, the word bits 14:0 read in that cycle still show the pre-clear value. At the next edge, every doorbell bit not set again in that same cycle becomes 0.
- R4: A bellSet pulse in the same cycle as a clearing read leaves its bit set after the edge.
- R5: Word bits 31:28 hold the index of the lowest-numbered set doorbell bit, or 15 when none is set.
- R6: Word bits 23:16 are queue flags in the order, from bit 16 upward: send0 room, recv0 data, send1 room, recv1 data, send2 room, recv2 data, send3 room, recv3 data. A recv-data flag is 1 exactly when that queue's get pointer differs from its put pointer.
- R7: A send-room flag is 1 exactly when that queue's enable bit is 1 and (put − get) is not equal to the queue size.
- R8: Word bits 27:24 hold the index (0 to 7) of the lowest set queue flag, or 15 when none is set.
- R9: irq is 1 exactly when any doorbell bit or any queue flag is set.
- R10: The put − get difference is taken modulo 2^PTR_W, so the send-room flag is correct after the put pointer wraps past zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bellSet | input | 15 | Per-doorbell set pulses |
| sendPut | input | 4*PTR_W | Send queue put pointers, queue q at bits q*PTR_W upward |
| sendGet | input | 4*PTR_W | Send queue get pointers |
| sendSize | input | 4*PTR_W | Send queue sizes in entries |
| sendEn | input | 4 | Per-send-queue flag enables |
| recvPut | input | 4*PTR_W | Receive queue put pointers |
| recvGet | input | 4*PTR_W | Receive queue get pointers |
| rdEn | input | 1 | Read strobe; clears doorbell bits at the next edge |
| rdData | output | 32 | Live status word |
| irq | output | 1 | Any-event interrupt |

## Verification
The checker verifies several properties on every cycle. It checks that the reserved bit stays zero and that doorbell bits persist without a read. It checks that a read clears the doorbell bits and that a same-cycle pulse survives the clear. It checks that each encoded field points at the lowest set bit, or reads 15 when none is set. It also checks the recv-data flags against the pointers and the interrupt line against the word.

The send-room flags involve the enable gating, the size comparison and the pointer wrap. These are shown only by the bench's reference model under its directed and random pointer scenarios. The reset word is also shown only by the bench.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int BELL_COUNT  = 15;
  localparam int QUEUE_COUNT = 4;
  localparam int ATT_COUNT   = 2 * QUEUE_COUNT;
  localparam int CODE_W      = 4;

  typedef struct packed {
    logic clearBells;
  } ctrl_t;
endpackage

// File: rtl/msg_lowest_first.sv
module msg_lowest_first #(
  parameter int N = 8,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] code
);
  always_comb begin
    code = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = W'(i);
    end
  end
endmodule

// File: rtl/msg_irq_ctl.sv
module msg_irq_ctl
  import msg_irq_pkg::*;
(
  input  logic  rdEn,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.clearBells = rdEn;
  end
endmodule

// File: rtl/msg_irq_dp.sv
module msg_irq_dp
  import msg_irq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrl_t                        ctrl,
  input  logic [BELL_COUNT-1:0]        bellSet,
  input  logic [QUEUE_COUNT*PTR_W-1:0] sendPut,
  input  logic [QUEUE_COUNT*PTR_W-1:0] sendGet,
  input  logic [QUEUE_COUNT*PTR_W-1:0] sendSize,
  input  logic [QUEUE_COUNT-1:0]       sendEn,
  input  logic [QUEUE_COUNT*PTR_W-1:0] recvPut,
  input  logic [QUEUE_COUNT*PTR_W-1:0] recvGet,
  output logic [31:0]                  rdData,
  output logic                         irq
);
  logic [BELL_COUNT-1:0] bells;
  logic [ATT_COUNT-1:0]  attn;
  logic [CODE_W-1:0]     bellCode;
  logic [CODE_W-1:0]     attnCode;

  always_ff @(posedge clk) begin
    if (!rst_n) bells <= '0;
    else        bells <= (ctrl.clearBells ? '0 : bells) | bellSet;
  end

  for (genvar q = 0; q < QUEUE_COUNT; q++) begin : g_queue
    logic [PTR_W-1:0] fill;
    assign fill          = sendPut[q*PTR_W +: PTR_W] - sendGet[q*PTR_W +: PTR_W];
    assign attn[2*q]     = sendEn[q] && (fill != sendSize[q*PTR_W +: PTR_W]);
    assign attn[2*q + 1] = recvPut[q*PTR_W +: PTR_W] != recvGet[q*PTR_W +: PTR_W];
  end

  msg_lowest_first #(.N(BELL_COUNT), .W(CODE_W)) u_bellEnc (.req(bells), .code(bellCode));
  msg_lowest_first #(.N(ATT_COUNT),  .W(CODE_W)) u_attnEnc (.req(attn),  .code(attnCode));

  assign rdData = {bellCode, attnCode, attn, 1'b0, bells};
  assign irq    = (|bells) || (|attn);
endmodule

// File: rtl/msg_irq_status.sv
module msg_irq_status
  import msg_irq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [14:0]            bellSet,
  input  logic [4*PTR_W-1:0]     sendPut,
  input  logic [4*PTR_W-1:0]     sendGet,
  input  logic [4*PTR_W-1:0]     sendSize,
  input  logic [3:0]             sendEn,
  input  logic [4*PTR_W-1:0]     recvPut,
  input  logic [4*PTR_W-1:0]     recvGet,
  input  logic                   rdEn,
  output logic [31:0]            rdData,
  output logic                   irq
);
  ctrl_t ctrl;

  msg_irq_ctl u_ctl (.rdEn(rdEn), .ctrl(ctrl));

  msg_irq_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bellSet(bellSet),
    .sendPut(sendPut), .sendGet(sendGet), .sendSize(sendSize), .sendEn(sendEn),
    .recvPut(recvPut), .recvGet(recvGet), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/msg_irq_status_chk.sv
module msg_irq_status_chk #(
  parameter int PTR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [14:0]        bellSet,
  input logic [4*PTR_W-1:0] recvPut,
  input logic [4*PTR_W-1:0] recvGet,
  input logic               rdEn,
  input logic [31:0]        rdData,
  input logic               irq
);
  logic [14:0] bellF;
  logic [7:0]  attF;
  logic [3:0]  bellC;
  logic [3:0]  attC;
  assign bellF = rdData[14:0];
  assign attF  = rdData[23:16];
  assign bellC = rdData[31:28];
  assign attC  = rdData[27:24];

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rdData[15] == 1'b0);

  // R2
  bell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> ((bellF & $past(bellF)) == $past(bellF)));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && bellSet == 15'd0) |=> (bellF == 15'd0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bellSet != 15'd0) |=> ((bellF & $past(bellSet)) == $past(bellSet)));

  // R5
  bell_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bellF == 15'd0) == (bellC == 4'd15));

  // R5
  bell_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bellF != 15'd0) |-> (bellF[bellC] &&
      ((bellF & ((15'd1 << bellC) - 15'd1)) == 15'd0)));

  // R8
  attn_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attF == 8'd0) == (attC == 4'd15));

  // R8
  attn_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attF != 8'd0) |-> (!attC[3] && attF[attC[2:0]] &&
      ((attF & ((8'd1 << attC[2:0]) - 8'd1)) == 8'd0)));

  // R9
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((bellF != 15'd0) || (attF != 8'd0)));

  for (genvar q = 0; q < 4; q++) begin : g_recv
    // R6
    recv_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attF[2*q + 1] == (recvPut[q*PTR_W +: PTR_W] != recvGet[q*PTR_W +: PTR_W]));
  end
endmodule

bind msg_irq_status msg_irq_status_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bellSet(bellSet), .recvPut(recvPut),
  .recvGet(recvGet), .rdEn(rdEn), .rdData(rdData), .irq(irq)
);

// File: tb/msg_irq_status_test.sv
`timescale 1ns/1ps
module msg_irq_status_test;
  localparam int PW = 8;
  localparam int MASK = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] bellSet = '0;
  logic [4*PW-1:0] sendPut = '0, sendGet = '0, sendSize = '0, recvPut = '0, recvGet = '0;
  logic [3:0] sendEn = '0;
  logic rdEn = 1'b0;
  logic [31:0] rdData;
  logic irq;

  int nCmp = 0;
  int nBad = 0;
  int mBells = 0;
  bit finished = 0;
  int sp[4], sg[4], sz[4], rp[4], rg[4];

  always #2.5 clk = ~clk;

  msg_irq_status #(.PTR_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .bellSet(bellSet), .sendPut(sendPut), .sendGet(sendGet),
    .sendSize(sendSize), .sendEn(sendEn), .recvPut(recvPut), .recvGet(recvGet),
    .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest(input int v, input int n);
    for (int i = 0; i < n; i++) if ((v >> i) & 1) return i;
    return 15;
  endfunction

  task automatic pack();
    for (int q = 0; q < 4; q++) begin
      sendPut[q*PW +: PW]  = PW'(sp[q]);
      sendGet[q*PW +: PW]  = PW'(sg[q]);
      sendSize[q*PW +: PW] = PW'(sz[q]);
      recvPut[q*PW +: PW]  = PW'(rp[q]);
      recvGet[q*PW +: PW]  = PW'(rg[q]);
    end
  endtask

  // Compare the live word against the model, then advance one clock.
  task automatic step(input int set, input bit rd);
    int att;
    bellSet = 15'(set);
    rdEn = rd;
    pack();
    #1;
    att = 0;
    for (int q = 0; q < 4; q++) begin
      if (sendEn[q] && (((sp[q] - sg[q]) & MASK) != sz[q])) att |= 1 << (2*q);
      if (rp[q] != rg[q]) att |= 1 << (2*q + 1);
    end
    check("R2/R3 bell bits", int'(rdData[14:0]), mBells);
    check("R2 reserved bit", int'(rdData[15]), 0);
    check("R7 send room", int'(rdData[23:16]) & 8'h55, att & 8'h55);
    check("R6 recv data", int'(rdData[23:16]) & 8'hAA, att & 8'hAA);
    check("R5 bell code", int'(rdData[31:28]), lowest(mBells, 15));
    check("R8 attn code", int'(rdData[27:24]), lowest(att, 8));
    check("R9 irq", int'(irq), int'((mBells != 0) || (att != 0)));
    @(posedge clk);
    mBells = (rd ? 0 : mBells) | set;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 4; q++) begin sp[q] = 0; sg[q] = 0; sz[q] = 4; rp[q] = 0; rg[q] = 0; end
    pack();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset word", int'(rdData), 32'hFF000000);
    check("R1 reset irq", int'(irq), 0);
    @(negedge clk);

    // R2 single bells accumulate and hold
    step(15'h0010, 0);
    step(0, 0);
    step(15'h4000, 0);
    step(0, 0);
    check("R5 lowest bell is 4", int'(rdData[31:28]), 4);
    // R3 read returns pre-clear value then clears
    check("R3 pre-clear value", int'(rdData[14:0]), 15'h4010);
    step(0, 1);
    step(0, 0);
    check("R3 cleared", int'(rdData[14:0]), 0);
    // R4 set during read survives
    step(15'h0003, 0);
    step(15'h0100, 1);
    step(0, 0);
    check("R4 set wins over clear", int'(rdData[14:0]), 15'h0100);
    step(15'h7FFF, 0);
    step(0, 1);
    // R6 receive queues
    rp[2] = 5; rg[2] = 3;
    step(0, 0);
    check("R8 recv2 index", int'(rdData[27:24]), 5);
    rp[0] = 9; rg[0] = 8;
    step(0, 0);
    // R7 send enable gating and size
    sendEn = 4'b0010; sp[1] = 4; sg[1] = 0; sz[1] = 4;
    step(0, 0);
    check("R7 full send queue no flag", int'(rdData[18]), 0);
    sg[1] = 1;
    step(0, 0);
    check("R7 room flag", int'(rdData[18]), 1);
    sendEn = 4'b0000;
    step(0, 0);
    check("R7 disabled", int'(rdData[18]), 0);
    // R10 wrap: put=3, get=250 -> fill 9
    sendEn = 4'b1000; sp[3] = 3; sg[3] = 250; sz[3] = 9;
    step(0, 0);
    check("R10 wrapped full", int'(rdData[22]), 0);
    sz[3] = 8;
    step(0, 0);
    check("R10 wrapped room", int'(rdData[22]), 1);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      int s;
      sendEn = 4'($urandom);
      for (int q = 0; q < 4; q++) begin
        sp[q] = $urandom & MASK; sg[q] = ($urandom % 2) ? sp[q] : ($urandom & MASK);
        sz[q] = ($urandom % 2) ? ((sp[q] - sg[q]) & MASK) : ($urandom % 16);
        rp[q] = $urandom & MASK; rg[q] = ($urandom % 2) ? rp[q] : ($urandom & MASK);
      end
      s = ($urandom % 3 == 0) ? int'(15'($urandom)) : 0;
      step(s, ($urandom % 5) == 0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule